// File: doc/BRIEF.md
# Compare-and-Branch Fusion Detector

This block sits in an instruction front end after pre-decode. Each cycle it may accept one pair of adjacent instructions. For each instruction it receives the operation class, the condition code, the immediate size, the starting byte address and the length in bytes. It decides whether the pair can be issued as one combined compare-and-branch micro-op. A fused pair leaves as a single merged descriptor. A pair that cannot fuse leaves as two unchanged descriptors, in program order.

Pairs flow through a two-stage pipeline, and the output order matches the input order. A mode input chooses between the wide (64-bit) rule set and the narrow (32-bit) rule set. A continuation flag marks a pair whose first instruction is the previous pair's second instruction. The block uses that flag to stop a branch that has already been absorbed into a fusion from being fused a second time.

Top module: `mf_fuse_detect`

## Requirements
- R1: Class codes are 0 other, 1 compare, 2 test, 3 add, 4 subtract, 5 increment, 6 decrement, 7 conditional jump. In wide mode (mode64=1) a pair fuses only when the first class is 1 to 6 and the second class is 7, and no blocking rule below applies.
- R2: A fused result has out_fuse=1 and out_cnt=1 (one micro-op). An unfused result has out_fuse=0 and out_cnt=2.
- R3: The merged descriptor carries kind = 8 + first class, the jump's condition code, the first instruction's immediate code and address, and a length equal to the sum of both lengths.
- R4: Immediate codes are 0 none, 1 8-bit, 2 32-bit, 3 64-bit. A first instruction with code 3 never fuses. Code 2 does not block fusion.
- R5: Let L be the last byte of the first instruction, at address plus length minus one. A pair never fuses when L and the jump's start address lie in different 64-byte lines. A pair whose first instruction ends on the jump's line fuses.
- R6: Jumps with condition code 10 (parity set) or 11 (parity clear) never fuse. Other condition codes do not block fusion.
- R7: In narrow mode (mode64=0) only compare and test may be the first instruction of a fused pair.
- R8: Each accepted pair produces exactly one result, with out_valid high two clock cycles after it is taken. Results come out in input order. out_valid is low during and after reset until a pair is accepted.
- R9: When in_cont=1 and the previous accepted pair fused, the current pair does not fuse. When in_cont=0, or when the previous pair did not fuse, the flag has no effect.
- R10: An unfused pair is emitted as slot 0 = first instruction and slot 1 = second instruction. Class, condition, immediate code, address and length are all copied unchanged, with the length zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode64 | input | 1 | 1 selects the wide rule set, 0 selects the narrow rule set |
| in_valid | input | 1 | A pair is presented this cycle |
| in_cont | input | 1 | The first instruction is the previous pair's second instruction |
| in0_class | input | 4 | First instruction class |
| in0_cond | input | 4 | First instruction condition code |
| in0_imm | input | 2 | First instruction immediate size code |
| in0_addr | input | ADDR_W | First instruction start byte address |
| in0_len | input | 4 | First instruction length in bytes |
| in1_class | input | 4 | Second instruction class |
| in1_cond | input | 4 | Second instruction condition code |
| in1_imm | input | 2 | Second instruction immediate size code |
| in1_addr | input | ADDR_W | Second instruction start byte address |
| in1_len | input | 4 | Second instruction length in bytes |
| out_valid | output | 1 | A result is present |
| out_fuse | output | 1 | The result is one merged micro-op |
| out_cnt | output | 2 | Number of micro-ops in the result (1 or 2) |
| out0_kind | output | 4 | Slot 0 kind |
| out0_cond | output | 4 | Slot 0 condition code |
| out0_imm | output | 2 | Slot 0 immediate code |
| out0_addr | output | ADDR_W | Slot 0 address |
| out0_len | output | 5 | Slot 0 length |
| out1_kind | output | 4 | Slot 1 kind (meaningful when out_cnt=2) |
| out1_cond | output | 4 | Slot 1 condition code |
| out1_imm | output | 2 | Slot 1 immediate code |
| out1_addr | output | ADDR_W | Slot 1 address |
| out1_len | output | 5 | Slot 1 length |

## Verification
The properties assume that mode64 and in_cont are held steady while a pair travels through the pipeline. They also assume that every presented length is nonzero, since the line-crossing test subtracts one from the end address. The stimulus meets both assumptions:
- It changes the mode only together with the pair it applies to, and the block registers the mode with that pair.
- It uses lengths from 1 to 15 only.
- It presents no pair until the internal reset has been released.

// File: rtl/mf_pkg.sv
package mf_pkg;
  localparam int CLS_W  = 4;
  localparam int COND_W = 4;
  localparam int IMM_W  = 2;
  localparam int LEN_W  = 4;
  localparam int OLEN_W = LEN_W + 1;
  localparam int NUM_CLS = 1 << CLS_W;

  localparam logic [CLS_W-1:0] CLS_OTHER = 4'd0;
  localparam logic [CLS_W-1:0] CLS_CMP   = 4'd1;
  localparam logic [CLS_W-1:0] CLS_TEST  = 4'd2;
  localparam logic [CLS_W-1:0] CLS_ADD   = 4'd3;
  localparam logic [CLS_W-1:0] CLS_SUB   = 4'd4;
  localparam logic [CLS_W-1:0] CLS_INC   = 4'd5;
  localparam logic [CLS_W-1:0] CLS_DEC   = 4'd6;
  localparam logic [CLS_W-1:0] CLS_JCC   = 4'd7;
  localparam logic [CLS_W-1:0] FUSED_TAG = 4'd8;

  localparam logic [COND_W-1:0] COND_PAR_SET = 4'd10;
  localparam logic [COND_W-1:0] COND_PAR_CLR = 4'd11;

  localparam logic [IMM_W-1:0] IMM_64 = 2'd3;

  typedef struct packed {
    logic [CLS_W-1:0]  cls;
    logic [COND_W-1:0] cond;
    logic [IMM_W-1:0]  imm;
    logic [LEN_W-1:0]  len;
  } insn_t;

  typedef struct packed {
    logic [CLS_W-1:0]  kind;
    logic [COND_W-1:0] cond;
    logic [IMM_W-1:0]  imm;
    logic [OLEN_W-1:0] len;
  } uop_t;

  // Whether a class may head a fused pair under the given mode.
  function automatic logic head_allowed(input logic [CLS_W-1:0] c, input logic wide);
    logic narrow_ok;
    logic wide_ok;
    narrow_ok = (c == CLS_CMP) || (c == CLS_TEST);
    wide_ok   = narrow_ok || (c == CLS_ADD) || (c == CLS_SUB) ||
                (c == CLS_INC) || (c == CLS_DEC);
    return wide ? wide_ok : narrow_ok;
  endfunction
endpackage

// File: rtl/mf_pattern.sv
module mf_pattern
  import mf_pkg::*;
(
  input  logic              mode64,
  input  logic [CLS_W-1:0]  head_cls,
  input  logic [IMM_W-1:0]  head_imm,
  input  logic [CLS_W-1:0]  tail_cls,
  input  logic [COND_W-1:0] tail_cond,
  output logic              pattern_ok
);
  logic [NUM_CLS-1:0] head_mask;
  logic               head_ok;
  logic               parity_jump;
  logic               wide_imm;

  // Eligible-head mask for the selected mode, one bit per class code.
  for (genvar g = 0; g < NUM_CLS; g++) begin : g_mask
    assign head_mask[g] = head_allowed(CLS_W'(g), mode64);
  end

  always_comb begin
    head_ok     = head_mask[head_cls];
    parity_jump = (tail_cond == COND_PAR_SET) || (tail_cond == COND_PAR_CLR);
    wide_imm    = (head_imm == IMM_64);
    pattern_ok  = head_ok && (tail_cls == CLS_JCC) && !parity_jump && !wide_imm;
  end
endmodule

// File: rtl/mf_line_check.sv
module mf_line_check
  import mf_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int LINE_BYTES = 64
) (
  input  logic [ADDR_W-1:0] head_addr,
  input  logic [LEN_W-1:0]  head_len,
  input  logic [ADDR_W-1:0] tail_addr,
  output logic              crosses
);
  localparam int LINE_LSB = $clog2(LINE_BYTES);

  logic [ADDR_W-1:0] head_last;
  logic [ADDR_W-1:0] diff;

  always_comb begin
    head_last = head_addr + ADDR_W'(head_len) - ADDR_W'(1);
    diff      = head_last ^ tail_addr;
    crosses   = (diff >> LINE_LSB) != '0;
  end
endmodule

// File: rtl/mf_merge.sv
module mf_merge
  import mf_pkg::*;
(
  input  logic   fuse,
  input  insn_t  head,
  input  insn_t  tail,
  output uop_t   slot0,
  output uop_t   slot1,
  output logic [1:0] count
);
  always_comb begin
    slot1.kind = tail.cls;
    slot1.cond = tail.cond;
    slot1.imm  = tail.imm;
    slot1.len  = OLEN_W'(tail.len);
    if (fuse) begin
      slot0.kind = head.cls | FUSED_TAG;
      slot0.cond = tail.cond;
      slot0.imm  = head.imm;
      slot0.len  = OLEN_W'(head.len) + OLEN_W'(tail.len);
      count      = 2'd1;
    end else begin
      slot0.kind = head.cls;
      slot0.cond = head.cond;
      slot0.imm  = head.imm;
      slot0.len  = OLEN_W'(head.len);
      count      = 2'd2;
    end
  end
endmodule

// File: rtl/mf_fuse_detect.sv
module mf_fuse_detect
  import mf_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int LINE_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode64,
  input  logic              in_valid,
  input  logic              in_cont,
  input  logic [3:0]        in0_class,
  input  logic [3:0]        in0_cond,
  input  logic [1:0]        in0_imm,
  input  logic [ADDR_W-1:0] in0_addr,
  input  logic [3:0]        in0_len,
  input  logic [3:0]        in1_class,
  input  logic [3:0]        in1_cond,
  input  logic [1:0]        in1_imm,
  input  logic [ADDR_W-1:0] in1_addr,
  input  logic [3:0]        in1_len,
  output logic              out_valid,
  output logic              out_fuse,
  output logic [1:0]        out_cnt,
  output logic [3:0]        out0_kind,
  output logic [3:0]        out0_cond,
  output logic [1:0]        out0_imm,
  output logic [ADDR_W-1:0] out0_addr,
  output logic [4:0]        out0_len,
  output logic [3:0]        out1_kind,
  output logic [3:0]        out1_cond,
  output logic [1:0]        out1_imm,
  output logic [ADDR_W-1:0] out1_addr,
  output logic [4:0]        out1_len
);
  // Reset synchroniser: assert asynchronously, release on the clock.
  logic [1:0] rst_pipe;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  // Stage 1: capture the pair.
  logic              s1_valid, s1_valid_d;
  logic              s1_cont,  s1_cont_d;
  logic              s1_mode,  s1_mode_d;
  insn_t             s1_head,  s1_head_d;
  insn_t             s1_tail,  s1_tail_d;
  logic [ADDR_W-1:0] s1_haddr, s1_haddr_d;
  logic [ADDR_W-1:0] s1_taddr, s1_taddr_d;

  always_comb begin
    s1_valid_d = in_valid;
    s1_cont_d  = s1_cont;
    s1_mode_d  = s1_mode;
    s1_head_d  = s1_head;
    s1_tail_d  = s1_tail;
    s1_haddr_d = s1_haddr;
    s1_taddr_d = s1_taddr;
    if (in_valid) begin
      s1_cont_d  = in_cont;
      s1_mode_d  = mode64;
      s1_head_d  = '{cls: in0_class, cond: in0_cond, imm: in0_imm, len: in0_len};
      s1_tail_d  = '{cls: in1_class, cond: in1_cond, imm: in1_imm, len: in1_len};
      s1_haddr_d = in0_addr;
      s1_taddr_d = in1_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      s1_valid <= 1'b0;
      s1_cont  <= 1'b0;
      s1_mode  <= 1'b0;
      s1_head  <= '0;
      s1_tail  <= '0;
      s1_haddr <= '0;
      s1_taddr <= '0;
    end else begin
      s1_valid <= s1_valid_d;
      s1_cont  <= s1_cont_d;
      s1_mode  <= s1_mode_d;
      s1_head  <= s1_head_d;
      s1_tail  <= s1_tail_d;
      s1_haddr <= s1_haddr_d;
      s1_taddr <= s1_taddr_d;
    end
  end

  // Decision logic.
  logic pattern_ok;
  logic line_cross;
  logic prev_fused, prev_fused_d;
  logic tail_taken;
  logic fuse_c;

  mf_pattern u_pattern (
    .mode64    (s1_mode),
    .head_cls  (s1_head.cls),
    .head_imm  (s1_head.imm),
    .tail_cls  (s1_tail.cls),
    .tail_cond (s1_tail.cond),
    .pattern_ok(pattern_ok)
  );

  mf_line_check #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_line (
    .head_addr(s1_haddr),
    .head_len (s1_head.len),
    .tail_addr(s1_taddr),
    .crosses  (line_cross)
  );

  always_comb begin
    tail_taken   = s1_cont && prev_fused;
    fuse_c       = pattern_ok && !line_cross && !tail_taken;
    prev_fused_d = s1_valid ? fuse_c : prev_fused;
  end

  uop_t       m_slot0, m_slot1;
  logic [1:0] m_count;

  mf_merge u_merge (
    .fuse (fuse_c),
    .head (s1_head),
    .tail (s1_tail),
    .slot0(m_slot0),
    .slot1(m_slot1),
    .count(m_count)
  );

  // Stage 2: result registers.
  logic              o_valid_d, o_fuse_d;
  logic [1:0]        o_cnt_d;
  uop_t              o_slot0, o_slot0_d, o_slot1, o_slot1_d;
  logic [ADDR_W-1:0] o_addr0, o_addr0_d, o_addr1, o_addr1_d;

  always_comb begin
    o_valid_d = s1_valid;
    o_fuse_d  = out_fuse;
    o_cnt_d   = out_cnt;
    o_slot0_d = o_slot0;
    o_slot1_d = o_slot1;
    o_addr0_d = o_addr0;
    o_addr1_d = o_addr1;
    if (s1_valid) begin
      o_fuse_d  = fuse_c;
      o_cnt_d   = m_count;
      o_slot0_d = m_slot0;
      o_slot1_d = m_slot1;
      o_addr0_d = s1_haddr;
      o_addr1_d = s1_taddr;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      out_valid  <= 1'b0;
      out_fuse   <= 1'b0;
      out_cnt    <= 2'd0;
      o_slot0    <= '0;
      o_slot1    <= '0;
      o_addr0    <= '0;
      o_addr1    <= '0;
      prev_fused <= 1'b0;
    end else begin
      out_valid  <= o_valid_d;
      out_fuse   <= o_fuse_d;
      out_cnt    <= o_cnt_d;
      o_slot0    <= o_slot0_d;
      o_slot1    <= o_slot1_d;
      o_addr0    <= o_addr0_d;
      o_addr1    <= o_addr1_d;
      prev_fused <= prev_fused_d;
    end
  end

  assign out0_kind = o_slot0.kind;
  assign out0_cond = o_slot0.cond;
  assign out0_imm  = o_slot0.imm;
  assign out0_len  = o_slot0.len;
  assign out0_addr = o_addr0;
  assign out1_kind = o_slot1.kind;
  assign out1_cond = o_slot1.cond;
  assign out1_imm  = o_slot1.imm;
  assign out1_len  = o_slot1.len;
  assign out1_addr = o_addr1;
endmodule

// File: rtl/mf_fuse_checker.sv
module mf_fuse_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       out_valid,
  input logic       out_fuse,
  input logic [1:0] out_cnt,
  input logic [3:0] out0_kind,
  input logic [3:0] out0_cond,
  input logic [1:0] out0_imm
);
  // R2: micro-op count agrees with the fuse flag
  a_r2_one_slot: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_fuse ? (out_cnt == 2'd1) : (out_cnt == 2'd2)));

  // R1 / R3: a merged kind always comes from an eligible head class
  a_r1_fused_kind: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_fuse) |-> (out0_kind >= 4'd9 && out0_kind <= 4'd14));

  // R4: no merged micro-op carries a 64-bit immediate
  a_r4_no_wide_imm: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_fuse) |-> (out0_imm != 2'd3));

  // R6: no merged micro-op carries a parity condition
  a_r6_no_parity: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_fuse) |-> (out0_cond != 4'd10 && out0_cond != 4'd11));

  // R8: every accepted pair yields a result two cycles later
  a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 out_valid);
endmodule

bind mf_fuse_detect mf_fuse_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_q_n),
  .in_valid (in_valid),
  .out_valid(out_valid),
  .out_fuse (out_fuse),
  .out_cnt  (out_cnt),
  .out0_kind(out0_kind),
  .out0_cond(out0_cond),
  .out0_imm (out0_imm)
);

// File: tb/sim_mf_fuse_detect.sv
module sim_mf_fuse_detect;
  localparam int AW = 64;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          mode64, in_valid, in_cont;
  logic [3:0]    in0_class, in0_cond, in1_class, in1_cond, in0_len, in1_len;
  logic [1:0]    in0_imm, in1_imm;
  logic [AW-1:0] in0_addr, in1_addr;
  logic          out_valid, out_fuse;
  logic [1:0]    out_cnt, out0_imm, out1_imm;
  logic [3:0]    out0_kind, out0_cond, out1_kind, out1_cond;
  logic [AW-1:0] out0_addr, out1_addr;
  logic [4:0]    out0_len, out1_len;

  always #5 clk = ~clk;

  mf_fuse_detect #(.ADDR_W(AW), .LINE_BYTES(64)) u0 (.*);

  typedef struct packed {
    logic          fuse;
    logic [1:0]    cnt;
    logic [3:0]    k0;
    logic [3:0]    c0;
    logic [1:0]    i0;
    logic [AW-1:0] a0;
    logic [4:0]    l0;
    logic [3:0]    k1;
    logic [3:0]    c1;
    logic [1:0]    i1;
    logic [AW-1:0] a1;
    logic [4:0]    l1;
  } res_t;

  res_t  exp_q[$];
  string tag_q[$];
  int    total = 0;
  int    bad   = 0;
  int    seen  = 0;
  int    sent  = 0;
  logic  last_fused = 1'b0;

  // Reference model built from the requirements.
  task automatic send(input string tag, input logic m, input logic cont,
                      input logic [3:0] c0, input logic [3:0] k0, input logic [1:0] i0,
                      input logic [AW-1:0] a0, input logic [3:0] l0,
                      input logic [3:0] c1, input logic [3:0] k1, input logic [1:0] i1,
                      input logic [AW-1:0] a1, input logic [3:0] l1);
    logic head_ok, fuse;
    logic [AW-1:0] last;
    res_t e;
    head_ok = m ? (c0 >= 4'd1 && c0 <= 4'd6) : (c0 == 4'd1 || c0 == 4'd2);
    last    = a0 + AW'(l0) - 1;
    fuse    = head_ok && (c1 == 4'd7) && (i0 != 2'd3) && (k1 != 4'd10) && (k1 != 4'd11)
              && (last[AW-1:6] == a1[AW-1:6]) && !(cont && last_fused);
    last_fused = fuse;
    e = '0;
    e.fuse = fuse;
    if (fuse) begin
      e.cnt = 2'd1; e.k0 = c0 + 4'd8; e.c0 = k1; e.i0 = i0; e.a0 = a0;
      e.l0 = 5'(l0) + 5'(l1);
    end else begin
      e.cnt = 2'd2; e.k0 = c0; e.c0 = k0; e.i0 = i0; e.a0 = a0; e.l0 = 5'(l0);
      e.k1 = c1; e.c1 = k1; e.i1 = i1; e.a1 = a1; e.l1 = 5'(l1);
    end
    @(negedge clk);
    mode64 = m; in_cont = cont; in_valid = 1'b1;
    in0_class = c0; in0_cond = k0; in0_imm = i0; in0_addr = a0; in0_len = l0;
    in1_class = c1; in1_cond = k1; in1_imm = i1; in1_addr = a1; in1_len = l1;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    sent++;
  endtask

  // Convenience: a head instruction followed directly by a second instruction.
  task automatic pair(input string tag, input logic m, input logic cont,
                      input logic [3:0] c0, input logic [1:0] i0, input logic [AW-1:0] a0,
                      input logic [3:0] l0, input logic [3:0] c1, input logic [3:0] k1);
    send(tag, m, cont, c0, 4'd3, i0, a0, l0, c1, k1, 2'd1, a0 + AW'(l0), 4'd2);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // Monitor / scoreboard.
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      res_t  a, e;
      string t;
      seen++;
      a = '0;
      a.fuse = out_fuse; a.cnt = out_cnt;
      a.k0 = out0_kind; a.c0 = out0_cond; a.i0 = out0_imm; a.a0 = out0_addr; a.l0 = out0_len;
      if (out_cnt != 2'd1) begin
        a.k1 = out1_kind; a.c1 = out1_cond; a.i1 = out1_imm; a.a1 = out1_addr; a.l1 = out1_len;
      end
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R8 unexpected result: actual=%h expected=none", a);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (a !== e) begin
          bad++;
          $display("FAIL %s actual=%h expected=%h", t, a, e);
        end
      end
    end
  end

  initial begin
    int wd;
    wd = 0;
    fork
      begin
        while (wd < 5000) begin
          @(posedge clk);
          wd++;
        end
        total++; bad++;
        $display("FAIL R8 watchdog expired actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    join_none
  end

  initial begin
    rst_n = 1'b0; mode64 = 1'b1; in_valid = 1'b0; in_cont = 1'b0;
    in0_class = '0; in0_cond = '0; in0_imm = '0; in0_addr = '0; in0_len = 4'd1;
    in1_class = '0; in1_cond = '0; in1_imm = '0; in1_addr = '0; in1_len = 4'd1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    total++;
    if (out_valid !== 1'b0) begin
      bad++;
      $display("FAIL R8 reset out_valid actual=%b expected=0", out_valid);
    end
    rst_n = 1'b1;
    idle(3);
    total++;
    if (out_valid !== 1'b0) begin
      bad++;
      $display("FAIL R8 idle after reset out_valid actual=%b expected=0", out_valid);
    end

    // R1 / R3: each eligible head in wide mode, back to back
    pair("R1 cmp", 1, 0, 4'd1, 2'd1, 64'h1000, 4'd3, 4'd7, 4'd4);
    pair("R1 test", 1, 0, 4'd2, 2'd0, 64'h1010, 4'd3, 4'd7, 4'd5);
    pair("R1 add", 1, 0, 4'd3, 2'd1, 64'h1020, 4'd4, 4'd7, 4'd2);
    pair("R1 sub", 1, 0, 4'd4, 2'd2, 64'h1030, 4'd6, 4'd7, 4'd3);
    pair("R1 inc", 1, 0, 4'd5, 2'd0, 64'h1080, 4'd3, 4'd7, 4'd8);
    pair("R3 dec", 1, 0, 4'd6, 2'd0, 64'h1090, 4'd2, 4'd7, 4'd12);
    // R1 / R10: ineligible head and non-jump tail pass through
    pair("R1 R10 other head", 1, 0, 4'd0, 2'd1, 64'h2000, 4'd5, 4'd7, 4'd4);
    pair("R1 R10 tail not jump", 1, 0, 4'd1, 2'd1, 64'h2010, 4'd3, 4'd1, 4'd0);
    idle(2);
    // R4: immediate size
    pair("R4 imm64", 1, 0, 4'd1, 2'd3, 64'h3000, 4'd10, 4'd7, 4'd4);
    pair("R4 imm32", 1, 0, 4'd1, 2'd2, 64'h3020, 4'd6, 4'd7, 4'd4);
    // R5: line boundary
    pair("R5 straddle", 1, 0, 4'd1, 2'd1, 64'h403C, 4'd4, 4'd7, 4'd4);
    pair("R5 same line", 1, 0, 4'd1, 2'd1, 64'h407A, 4'd4, 4'd7, 4'd4);
    pair("R5 ends on next line", 1, 0, 4'd1, 2'd1, 64'h40BD, 4'd4, 4'd7, 4'd4);
    // R6: parity conditions
    pair("R6 parity set", 1, 0, 4'd2, 2'd0, 64'h5000, 4'd3, 4'd7, 4'd10);
    pair("R6 parity clear", 1, 0, 4'd2, 2'd0, 64'h5010, 4'd3, 4'd7, 4'd11);
    pair("R6 other cond", 1, 0, 4'd2, 2'd0, 64'h5020, 4'd3, 4'd7, 4'd12);
    idle(1);
    // R7: narrow mode
    pair("R7 narrow add", 0, 0, 4'd3, 2'd1, 64'h6000, 4'd3, 4'd7, 4'd4);
    pair("R7 narrow cmp", 0, 0, 4'd1, 2'd1, 64'h6010, 4'd3, 4'd7, 4'd4);
    pair("R7 narrow test", 0, 0, 4'd2, 2'd0, 64'h6020, 4'd2, 4'd7, 4'd5);
    pair("R7 narrow dec", 0, 0, 4'd6, 2'd0, 64'h6030, 4'd2, 4'd7, 4'd5);
    // R9: continuation after a fusion is blocked
    pair("R9 first fuses", 1, 0, 4'd1, 2'd1, 64'h7000, 4'd3, 4'd7, 4'd4);
    pair("R9 consumed head", 1, 1, 4'd1, 2'd1, 64'h7003, 4'd2, 4'd7, 4'd4);
    pair("R9 cont after no fuse", 1, 1, 4'd1, 2'd1, 64'h7005, 4'd2, 4'd7, 4'd4);
    pair("R9 no cont after fuse", 1, 0, 4'd1, 2'd1, 64'h7040, 4'd2, 4'd7, 4'd4);
    // R10: full descriptor pass-through, distinct field values
    send("R10 passthrough", 1, 0, 4'd0, 4'd9, 2'd2, 64'hDEAD_BEEF_0000_1230, 4'd15,
         4'd5, 4'd6, 2'd3, 64'h0123_4567_89AB_CDEF, 4'd11);
    idle(6);

    total++;
    if (seen != sent || exp_q.size() != 0) begin
      bad++;
      $display("FAIL R8 result count actual=%0d expected=%0d", seen, sent);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule